// File: doc/BRIEF.md
# Memory Overlay Address Mapper

This block sits between a processor core and its memory buses. It takes a 14-bit core address tagged as program or data space and decides whether the access goes to on-chip memory or to an external bus. Each space has a fixed overlay window of 8K words. Inside that window, the space's overlay value picks internal memory (0) or one of two external 8K segments (1 or 2). The segment number drives external address bit 13, so two external segments fit in the normal 14-bit address space. Outside the window, the access always stays internal.

Requests arrive on a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high while the block is idle, and also in the final cycle of an access, so a new request can follow without a gap. When `req_ready` is low the requester must hold its request; nothing is queued. Once taken, the decode, the external address and the wait count are held in registers for the whole access. `acc_done` pulses in the cycle in which the access completes. A boot strap disables program-space overlays. Data-space accesses to the top 32 words are flagged as register accesses.

Top module: `ovl_map`

## Requirements
- R1: In the cycle after a request is taken, `ext_sel` is 0 when the selected overlay value is 0 or the address lies outside that space's window; the access is then internal.
- R2: The program window is 0x2000–0x3FFF (address bit 13 = 1). The data window is 0x0000–0x1FFF (address bit 13 = 0). `req_space` 0 means program and 1 means data.
- R3: An overlay value of 1 inside the window gives `ext_sel`=1 and `ext_addr[13]`=0. A value of 2 gives `ext_sel`=1 and `ext_addr[13]`=1. In both cases `ext_addr[12:0]` equals the core address bits 12:0.
- R4: When `boot_strap` is 1, the program overlay value is treated as 0. The data overlay still applies.
- R5: An overlay value of 3 or more inside the window gives `ext_sel`=0 and `ovl_err`=1 for that access. `ovl_err` is 0 at all other times.
- R6: An internal or reserved access raises `acc_done` in its first active cycle, which is the cycle after the request is taken.
- R7: An external access raises `acc_done` in its (W+1)th active cycle. W is the `ext_wait` value sampled when the request is taken.
- R8: `ext_sel`, `ext_addr`, `ovl_err` and `mmr_sel` hold steady for the whole access, even if the request inputs change after acceptance.
- R9: `mmr_sel` is 1 during a data-space access to 0x3FE0–0x3FFF and 0 otherwise.
- R10: `req_ready` is 1 when idle and in the `acc_done` cycle, and 0 in other active cycles. `acc_done` lasts one cycle. `ext_sel` is 0 while idle.
- R11: After reset the block is idle: `req_ready`=1, and `acc_active`, `ext_sel`, `ovl_err`, `mmr_sel` and `acc_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can take a request this cycle |
| req_space | input | 1 | 0 = program space, 1 = data space |
| req_addr | input | 14 | Core address |
| pm_ovl | input | 3 | Program-space overlay value |
| dm_ovl | input | 3 | Data-space overlay value |
| boot_strap | input | 1 | 1 disables program-space overlays |
| ext_wait | input | 3 | Wait states for external accesses |
| acc_active | output | 1 | An access is in progress |
| ext_sel | output | 1 | The current access goes to the external bus |
| ext_addr | output | 14 | External bus address |
| mmr_sel | output | 1 | The current access hits the data register block |
| ovl_err | output | 1 | The current access used a reserved overlay value |
| acc_done | output | 1 | The access completes this cycle |

## Verification
The assertions watch several rules on every cycle. Select and address must stay steady while an access lasts. Ready must follow the active/done state. A reserved overlay must never reach the external bus. The number of active cycles must match the captured wait count for external accesses and be exactly one otherwise. Other behaviour can only be shown by the bench's scenarios, which compare against an independent model: that the window chosen for each space is correct, that bit 13 carries the segment number, that the boot strap masks only the program overlay, and that the register block is flagged at the 0x3FDF/0x3FE0 boundary.

// File: rtl/ovl_map_pkg.sv
package ovl_map_pkg;
  typedef enum logic {
    SP_PROG = 1'b0,
    SP_DATA = 1'b1
  } space_e;

  typedef enum logic [1:0] {
    AK_INT = 2'd0,
    AK_EXT = 2'd1,
    AK_RSV = 2'd2
  } kind_e;
endpackage

// File: rtl/ovl_map_dec.sv
module ovl_map_dec
  import ovl_map_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int OVL_W  = 3,
  parameter int MMR_N  = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  space_e            space,
  input  logic [OVL_W-1:0]  pm_ovl,
  input  logic [OVL_W-1:0]  dm_ovl,
  input  logic              strap,
  output kind_e             kind,
  output logic [ADDR_W-1:0] xaddr,
  output logic              mmr
);
  localparam int SEG_W = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] MMR_BASE = ADDR_W'((1 << ADDR_W) - MMR_N);

  logic [OVL_W-1:0] ovl;
  logic             in_win;

  always_comb begin
    if (space == SP_PROG) begin
      ovl    = strap ? '0 : pm_ovl;
      in_win = addr[ADDR_W-1];
    end else begin
      ovl    = dm_ovl;
      in_win = ~addr[ADDR_W-1];
    end

    if (!in_win || ovl == '0)
      kind = AK_INT;
    else if (ovl == OVL_W'(1) || ovl == OVL_W'(2))
      kind = AK_EXT;
    else
      kind = AK_RSV;

    xaddr = {ovl == OVL_W'(2), addr[SEG_W-1:0]};
    mmr   = (space == SP_DATA) && (addr >= MMR_BASE);
  end
endmodule

// File: rtl/ovl_map_wait.sv
module ovl_map_wait #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              active,
  output logic              zero
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (active && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ovl_map.sv
module ovl_map
  import ovl_map_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int OVL_W  = 3,
  parameter int WAIT_W = 3,
  parameter int MMR_N  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [OVL_W-1:0]  pm_ovl,
  input  logic [OVL_W-1:0]  dm_ovl,
  input  logic              boot_strap,
  input  logic [WAIT_W-1:0] ext_wait,
  output logic              acc_active,
  output logic              ext_sel,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              mmr_sel,
  output logic              ovl_err,
  output logic              acc_done
);
  kind_e             dec_kind;
  logic [ADDR_W-1:0] dec_xaddr;
  logic              dec_mmr;
  logic              accept;
  logic              wait_zero;
  logic [WAIT_W-1:0] wait_load;

  logic              busy_q;
  logic              ext_q;
  logic              err_q;
  logic              mmr_q;
  logic [ADDR_W-1:0] addr_q;

  ovl_map_dec #(
    .ADDR_W(ADDR_W),
    .OVL_W (OVL_W),
    .MMR_N (MMR_N)
  ) u_dec (
    .addr  (req_addr),
    .space (space_e'(req_space)),
    .pm_ovl(pm_ovl),
    .dm_ovl(dm_ovl),
    .strap (boot_strap),
    .kind  (dec_kind),
    .xaddr (dec_xaddr),
    .mmr   (dec_mmr)
  );

  assign wait_load = (dec_kind == AK_EXT) ? ext_wait : '0;

  ovl_map_wait #(
    .WAIT_W(WAIT_W)
  ) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .load_val(wait_load),
    .active  (busy_q),
    .zero    (wait_zero)
  );

  assign acc_done  = busy_q & wait_zero;
  assign req_ready = ~busy_q | acc_done;
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ext_q  <= 1'b0;
      err_q  <= 1'b0;
      mmr_q  <= 1'b0;
      addr_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      ext_q  <= (dec_kind == AK_EXT);
      err_q  <= (dec_kind == AK_RSV);
      mmr_q  <= dec_mmr;
      addr_q <= dec_xaddr;
    end else if (acc_done) begin
      busy_q <= 1'b0;
    end
  end

  assign acc_active = busy_q;
  assign ext_sel    = busy_q & ext_q;
  assign ovl_err    = busy_q & err_q;
  assign mmr_sel    = busy_q & mmr_q;
  assign ext_addr   = addr_q;
endmodule

// File: rtl/ovl_map_chk.sv
module ovl_map_chk #(
  parameter int ADDR_W = 14,
  parameter int OVL_W  = 3,
  parameter int WAIT_W = 3,
  parameter int MMR_N  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [WAIT_W-1:0] ext_wait,
  input logic              acc_active,
  input logic              ext_sel,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              mmr_sel,
  input logic              ovl_err,
  input logic              acc_done
);
  logic [WAIT_W:0]   cyc_q;
  logic [WAIT_W-1:0] wcap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      wcap_q <= '0;
    end else if (req_valid && req_ready) begin
      cyc_q  <= '0;
      wcap_q <= ext_wait;
    end else if (acc_active) begin
      cyc_q  <= cyc_q + 1'b1;
    end
  end

  AST_IDLE_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_active |-> (!ext_sel && !ovl_err && !mmr_sel && !acc_done)); // R10
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_active |-> req_ready); // R10
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_active && !acc_done) |-> !req_ready); // R10
  AST_ERR_NOT_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_err |-> !ext_sel); // R5
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_active && !acc_done) |=> (acc_active && $stable(ext_sel) && $stable(ext_addr)
                                   && $stable(ovl_err) && $stable(mmr_sel))); // R8
  AST_INT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_active && !ext_sel) |-> (acc_done && cyc_q == '0)); // R6
  AST_EXT_WAIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && ext_sel) |-> (cyc_q == {1'b0, wcap_q})); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && !(req_valid && req_ready)) |=> !acc_done); // R10
endmodule

bind ovl_map ovl_map_chk #(
  .ADDR_W(ADDR_W),
  .OVL_W (OVL_W),
  .WAIT_W(WAIT_W),
  .MMR_N (MMR_N)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ext_wait  (ext_wait),
  .acc_active(acc_active),
  .ext_sel   (ext_sel),
  .ext_addr  (ext_addr),
  .mmr_sel   (mmr_sel),
  .ovl_err   (ovl_err),
  .acc_done  (acc_done)
);

// File: tb/ovl_map_tb.sv
module ovl_map_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_space = 1'b0;
  logic [13:0] req_addr = '0;
  logic [2:0]  pm_ovl = '0;
  logic [2:0]  dm_ovl = '0;
  logic        boot_strap = 1'b0;
  logic [2:0]  ext_wait = '0;
  logic        acc_active;
  logic        ext_sel;
  logic [13:0] ext_addr;
  logic        mmr_sel;
  logic        ovl_err;
  logic        acc_done;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ovl_map u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_space(req_space), .req_addr(req_addr), .pm_ovl(pm_ovl), .dm_ovl(dm_ovl),
    .boot_strap(boot_strap), .ext_wait(ext_wait), .acc_active(acc_active),
    .ext_sel(ext_sel), .ext_addr(ext_addr), .mmr_sel(mmr_sel), .ovl_err(ovl_err),
    .acc_done(acc_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // 0 internal, 1 external, 2 reserved
  function automatic int exp_kind(bit sp, logic [13:0] a, int pm, int dm, bit st);
    int  ov;
    bit  win;
    ov  = sp ? dm : (st ? 0 : pm);
    win = sp ? (a < 14'h2000) : (a >= 14'h2000);
    if (!win || ov == 0) return 0;
    if (ov == 1 || ov == 2) return 1;
    return 2;
  endfunction

  function automatic int exp_xaddr(bit sp, logic [13:0] a, int pm, int dm, bit st);
    int ov;
    ov = sp ? dm : (st ? 0 : pm);
    return ((ov == 2) ? 32'h2000 : 32'h0) | int'(a & 14'h1FFF);
  endfunction

  function automatic bit exp_mmr(bit sp, logic [13:0] a);
    return sp && (a >= 14'h3FE0);
  endfunction

  // Called at a falling edge with the block ready; returns at the falling edge of the done cycle.
  task automatic run_acc(input bit sp, input logic [13:0] a, input int pm, input int dm,
                         input bit st, input int w, input bit scramble);
    int k;
    int kd;
    int xa;
    bit s_ext, s_err, s_mmr;
    logic [13:0] s_addr;
    kd = exp_kind(sp, a, pm, dm, st);
    xa = exp_xaddr(sp, a, pm, dm, st);
    chk("R10 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_space = sp; req_addr = a; pm_ovl = 3'(pm); dm_ovl = 3'(dm);
    boot_strap = st; ext_wait = 3'(w);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin
      req_addr = 14'($urandom); pm_ovl = 3'($urandom); dm_ovl = 3'($urandom);
      req_space = ~sp; boot_strap = ~st; ext_wait = 3'($urandom);
    end
    chk("R11 active after accept", int'(acc_active), 1);
    chk("R1 R2 R4 ext_sel", int'(ext_sel), (kd == 1) ? 1 : 0);
    chk("R5 ovl_err", int'(ovl_err), (kd == 2) ? 1 : 0);
    chk("R9 mmr_sel", int'(mmr_sel), int'(exp_mmr(sp, a)));
    if (kd == 1) chk("R3 ext_addr", int'(ext_addr), xa);
    k = 1;
    while (!acc_done && k < 20) begin
      s_ext = ext_sel; s_err = ovl_err; s_mmr = mmr_sel; s_addr = ext_addr;
      chk("R10 not ready mid access", int'(req_ready), 0);
      @(negedge clk);
      k++;
      chk("R8 hold", int'({s_ext, s_err, s_mmr, s_addr}),
          int'({ext_sel, ovl_err, mmr_sel, ext_addr}));
    end
    if (kd == 1) chk("R7 external latency", k, w + 1);
    else         chk("R6 internal latency", k, 1);
    chk("R10 ready in done cycle", int'(req_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready", int'(req_ready), 1);
    chk("R11 active", int'(acc_active), 0);
    chk("R11 ext_sel", int'(ext_sel), 0);
    chk("R11 done", int'(acc_done), 0);
    chk("R11 err/mmr", int'({ovl_err, mmr_sel}), 0);

    run_acc(1'b0, 14'h0123, 1, 0, 1'b0, 3, 1'b0); // R2 program below window stays internal
    run_acc(1'b0, 14'h2ABC, 1, 0, 1'b0, 2, 1'b0); // R3 segment 1
    run_acc(1'b0, 14'h3ABC, 2, 0, 1'b0, 0, 1'b0); // R3 segment 2, zero waits
    run_acc(1'b0, 14'h2ABC, 2, 2, 1'b1, 4, 1'b0); // R4 strap masks program overlay
    run_acc(1'b1, 14'h1234, 1, 2, 1'b1, 7, 1'b1); // R4 data overlay survives strap, R7 max wait
    run_acc(1'b1, 14'h2000, 0, 1, 1'b0, 5, 1'b0); // R2 data above window
    run_acc(1'b1, 14'h1FFF, 0, 3, 1'b0, 5, 1'b0); // R5 reserved
    run_acc(1'b0, 14'h3FFF, 7, 0, 1'b0, 5, 1'b0); // R5 reserved program
    run_acc(1'b1, 14'h3FE0, 0, 1, 1'b0, 1, 1'b0); // R9 first register word
    run_acc(1'b1, 14'h3FDF, 0, 1, 1'b0, 1, 1'b0); // R9 last plain word
    run_acc(1'b0, 14'h3FE0, 0, 0, 1'b0, 1, 1'b0); // R9 program space never register
    run_acc(1'b1, 14'h0000, 0, 0, 1'b0, 6, 1'b0); // R1 overlay 0

    for (int i = 0; i < 400; i++) begin
      run_acc(1'($urandom), 14'($urandom), int'($urandom_range(0, 4)),
              int'($urandom_range(0, 4)), 1'($urandom_range(0, 3) == 0),
              int'($urandom_range(0, 7)), 1'($urandom));
    end

    @(negedge clk);
    chk("R10 idle after done", int'(acc_active), 0);
    chk("R10 ext_sel idle", int'(ext_sel), 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule